// File: doc/BRIEF.md
# Address Translation Decision Sequencer

This block takes one memory access at a time and settles its translation outcome. It looks at the access kind (instruction fetch, data load or data store), the privilege mode and the translation enables. It also takes the result of a block-translation match, a bank of sixteen 32-bit segment descriptors and the outcome of a page-table walk. From these it returns either a grant, made of a physical address and a read/write/execute permission vector, or a fault. A fault carries its side (instruction or data) and a 32-bit status code. Data-side faults also capture the faulting effective address.

The checks are applied in a fixed order. Real mode comes first, then the block-translation result, then the segment chosen by the top four address bits. A direct-store segment is handled next, then segment no-execute, then the walk result, and last the page permission check. The first stage that decides ends the evaluation. The walk and the block matcher sit outside the block and present their results on the request.

A request is accepted when `req_valid` and `req_ready` are both high. The result appears one cycle later and stays held until `resp_ack` is given.

Top module: `xfs_top`

## Requirements
- R1: Real mode. When the relevant enable is low, the access is granted with phys_addr equal to eff_addr and perm = 3'b111. Fetches (acc_kind 0) use ifetch_xlat_en. Loads (1), stores (2) and code 3, which behaves as a load, use data_xlat_en.
- R2: With translation on and blk_hit high, the block result decides alone and the walk inputs are ignored. If blk_perm lacks the needed bit, a protection fault is reported. Otherwise the access is granted with blk_pa and blk_perm. The needed bit is perm bit 2 (X) for a fetch, bit 1 (W) for a store and bit 0 (R) for a load.
- R3: The segment descriptor is word eff_addr[31:28] of seg_file, with word i at bits 32*i+31:32*i. Its access key is bit 29 in user mode and bit 30 in supervisor mode.
- R4: Page protection walk_pp decodes as follows. With key 0, values 0, 1 and 2 give read/write and 3 gives read only. With key 1, value 0 gives nothing, 1 and 3 give read only, and 2 gives read/write.
- R5: X is added to the page permission only when segment bit 28 (no-execute) is clear. A fetch from a segment with bit 31 clear and bit 28 set raises an instruction fault with status 0x10000000.
- R6: A fetch from a direct-store segment (bit 31 set) whose bus field is not 0x07F raises an instruction fault with status 0x10000000.
- R7: In a direct-store segment whose bus field (bits 28:20) equals 0x07F, any access is granted. Its address is {segment bits 3:0, eff_addr[27:0]} and perm is 3'b111.
- R8: Other direct-store data accesses are granted with phys_addr = eff_addr and perm = 3'b011. The exceptions are a store with key 1 and a load with key 0, which raise a protection fault.
- R9: When walk_found is low, the access faults with status 0x40000000, or 0x42000000 for a store.
- R10: A page or block protection fault gives status 0x08000000, or 0x0A000000 for a store. A page grant gives phys_addr = {walk_rpn, eff_addr[11:0]} with the decoded permission. The status is 0 on every grant.
- R11: A fetch fault sets fault_instr and every other fault sets fault_data, never both and never with grant. fault_addr takes eff_addr on data faults only and otherwise keeps its value.
- R12: The result is registered and appears in the cycle after acceptance. While resp_valid is high, req_ready is low, outputs are held and new requests are ignored until resp_ack. After reset, all outputs are zero and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| user_mode | input | 1 | 1 = user privilege |
| ifetch_xlat_en | input | 1 | Instruction-side translation enable |
| data_xlat_en | input | 1 | Data-side translation enable |
| blk_hit | input | 1 | Block translation matched |
| blk_perm | input | 3 | Block permission {X,W,R} |
| blk_pa | input | 32 | Block physical address |
| eff_addr | input | 32 | Effective address |
| seg_file | input | 512 | Sixteen segment descriptors |
| walk_found | input | 1 | Page-table walk found an entry |
| walk_pp | input | 2 | Page protection value |
| walk_rpn | input | 20 | Physical page number |
| resp_valid | output | 1 | Result held |
| resp_ack | input | 1 | Result consumed |
| grant | output | 1 | Access granted |
| phys_addr | output | 32 | Physical address |
| perm | output | 3 | Granted permission {X,W,R} |
| fault_instr | output | 1 | Instruction-side fault |
| fault_data | output | 1 | Data-side fault |
| status | output | 32 | Fault status code |
| fault_addr | output | 32 | Last data-fault effective address |

## Verification
The assertions check on every cycle that held results stay stable until acknowledged, that grant and the two fault flags stay exclusive, and that fetches never flag a data fault. They also check that real-mode accesses are granted with full permission, that no-execute fetches fault with the right code, and that data faults capture the address. Only the bench scenarios show the ordering between stages, the full key and protection table, the direct-store paths, the store-specific status codes and that walk inputs are ignored after a block hit. These scenarios compare every output against an independent reference model over directed and seeded random accesses.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  localparam int PERM_W   = 3;
  localparam int P_RD     = 0;
  localparam int P_WR     = 1;
  localparam int P_EX     = 2;
  localparam int SEG_W    = 32;
  localparam int ST_W     = 32;

  // segment descriptor bit positions
  localparam int SEG_DS   = 31;
  localparam int SEG_KSUP = 30;
  localparam int SEG_KUSR = 29;
  localparam int SEG_NOX  = 28;
  localparam int BUS_HI   = 28;
  localparam int BUS_LO   = 20;
  localparam int FRC_HI   = 3;
  localparam logic [BUS_HI-BUS_LO:0] BUS_FORCED = 9'h07F;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOADX = 2'd3
  } acc_e;

  localparam logic [ST_W-1:0] ST_OK      = 32'h0000_0000;
  localparam logic [ST_W-1:0] ST_NOEXEC  = 32'h1000_0000;
  localparam logic [ST_W-1:0] ST_MISS    = 32'h4000_0000;
  localparam logic [ST_W-1:0] ST_MISS_ST = 32'h4200_0000;
  localparam logic [ST_W-1:0] ST_PROT    = 32'h0800_0000;
  localparam logic [ST_W-1:0] ST_PROT_ST = 32'h0A00_0000;
endpackage

// File: rtl/xfs_seg_sel.sv
module xfs_seg_sel #(
  parameter int NSEG  = 16,
  parameter int SW    = 32,
  localparam int IDXW = $clog2(NSEG)
) (
  input  logic [NSEG*SW-1:0] seg_file,
  input  logic [IDXW-1:0]    idx,
  output logic [SW-1:0]      seg_out
);
  logic [SW-1:0] words [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_unpack
    assign words[g] = seg_file[g*SW +: SW];
  end

  assign seg_out = words[idx];
endmodule

// File: rtl/xfs_key_prot.sv
module xfs_key_prot
  import xfs_pkg::*;
(
  input  logic              user_mode,
  input  logic              key_sup,
  input  logic              key_usr,
  input  logic              no_exec,
  input  logic [1:0]        pp,
  output logic              key,
  output logic [PERM_W-1:0] page_perm
);
  logic [PERM_W-1:0] rw;

  assign key = user_mode ? key_usr : key_sup;

  always_comb begin
    rw = '0;
    if (!key) begin
      rw[P_RD] = 1'b1;
      rw[P_WR] = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0:    rw = '0;
        2'd2:    begin rw[P_RD] = 1'b1; rw[P_WR] = 1'b1; end
        default: rw[P_RD] = 1'b1;
      endcase
    end
    page_perm       = rw;
    page_perm[P_EX] = !no_exec;
  end
endmodule

// File: rtl/xfs_decide.sv
module xfs_decide
  import xfs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  localparam int RPNW     = AW - PAGE_BITS
) (
  input  acc_e              acc,
  input  logic              user_mode,
  input  logic              ifetch_xlat_en,
  input  logic              data_xlat_en,
  input  logic              blk_hit,
  input  logic [PERM_W-1:0] blk_perm,
  input  logic [AW-1:0]     blk_pa,
  input  logic [AW-1:0]     ea,
  input  logic [SEG_W-1:0]  seg,
  input  logic              walk_found,
  input  logic [1:0]        walk_pp,
  input  logic [RPNW-1:0]   walk_rpn,
  output logic              d_grant,
  output logic [AW-1:0]     d_pa,
  output logic [PERM_W-1:0] d_perm,
  output logic              d_finstr,
  output logic              d_fdata,
  output logic [ST_W-1:0]   d_status
);
  logic              is_fetch, is_store, xlat_on, key;
  logic [PERM_W-1:0] need, page_perm;
  logic              unused_seg;

  assign unused_seg = ^seg[BUS_LO-1:FRC_HI+1];
  assign is_fetch   = (acc == ACC_FETCH);
  assign is_store   = (acc == ACC_STORE);
  assign xlat_on    = is_fetch ? ifetch_xlat_en : data_xlat_en;

  always_comb begin
    need = '0;
    if (is_fetch)      need[P_EX] = 1'b1;
    else if (is_store) need[P_WR] = 1'b1;
    else               need[P_RD] = 1'b1;
  end

  xfs_key_prot u_kp (
    .user_mode (user_mode),
    .key_sup   (seg[SEG_KSUP]),
    .key_usr   (seg[SEG_KUSR]),
    .no_exec   (seg[SEG_NOX]),
    .pp        (walk_pp),
    .key       (key),
    .page_perm (page_perm)
  );

  always_comb begin
    d_grant  = 1'b0;
    d_pa     = '0;
    d_perm   = '0;
    d_finstr = 1'b0;
    d_fdata  = 1'b0;
    d_status = ST_OK;
    if (!xlat_on) begin
      d_grant = 1'b1;
      d_pa    = ea;
      d_perm  = '1;
    end else if (blk_hit) begin
      if (|(need & ~blk_perm)) begin
        d_finstr = is_fetch;
        d_fdata  = !is_fetch;
        d_status = is_store ? ST_PROT_ST : ST_PROT;
      end else begin
        d_grant = 1'b1;
        d_pa    = blk_pa;
        d_perm  = blk_perm;
      end
    end else if (seg[SEG_DS]) begin
      if (seg[BUS_HI:BUS_LO] == BUS_FORCED) begin
        d_grant = 1'b1;
        d_pa    = {seg[FRC_HI:0], ea[AW-FRC_HI-2:0]};
        d_perm  = '1;
      end else if (is_fetch) begin
        d_finstr = 1'b1;
        d_status = ST_NOEXEC;
      end else if ((is_store && key) || (!is_store && !key)) begin
        d_fdata  = 1'b1;
        d_status = is_store ? ST_PROT_ST : ST_PROT;
      end else begin
        d_grant      = 1'b1;
        d_pa         = ea;
        d_perm[P_RD] = 1'b1;
        d_perm[P_WR] = 1'b1;
      end
    end else if (is_fetch && seg[SEG_NOX]) begin
      d_finstr = 1'b1;
      d_status = ST_NOEXEC;
    end else if (!walk_found) begin
      d_finstr = is_fetch;
      d_fdata  = !is_fetch;
      d_status = is_store ? ST_MISS_ST : ST_MISS;
    end else if (|(need & ~page_perm)) begin
      d_finstr = is_fetch;
      d_fdata  = !is_fetch;
      d_status = is_store ? ST_PROT_ST : ST_PROT;
    end else begin
      d_grant = 1'b1;
      d_pa    = {walk_rpn, ea[PAGE_BITS-1:0]};
      d_perm  = page_perm;
    end
  end
endmodule

// File: rtl/xfs_top.sv
module xfs_top
  import xfs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int NSEG      = 16,
  localparam int RPNW     = AW - PAGE_BITS,
  localparam int IDXW     = $clog2(NSEG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            acc_kind,
  input  logic                  user_mode,
  input  logic                  ifetch_xlat_en,
  input  logic                  data_xlat_en,
  input  logic                  blk_hit,
  input  logic [PERM_W-1:0]     blk_perm,
  input  logic [AW-1:0]         blk_pa,
  input  logic [AW-1:0]         eff_addr,
  input  logic [NSEG*SEG_W-1:0] seg_file,
  input  logic                  walk_found,
  input  logic [1:0]            walk_pp,
  input  logic [RPNW-1:0]       walk_rpn,
  output logic                  resp_valid,
  input  logic                  resp_ack,
  output logic                  grant,
  output logic [AW-1:0]         phys_addr,
  output logic [PERM_W-1:0]     perm,
  output logic                  fault_instr,
  output logic                  fault_data,
  output logic [ST_W-1:0]       status,
  output logic [AW-1:0]         fault_addr
);
  logic [SEG_W-1:0]  seg_cur;
  logic              d_grant, d_finstr, d_fdata;
  logic [AW-1:0]     d_pa;
  logic [PERM_W-1:0] d_perm;
  logic [ST_W-1:0]   d_status;
  logic              accept;

  assign req_ready = !resp_valid;
  assign accept    = req_valid && req_ready;

  xfs_seg_sel #(.NSEG(NSEG), .SW(SEG_W)) u_sel (
    .seg_file (seg_file),
    .idx      (eff_addr[AW-1 -: IDXW]),
    .seg_out  (seg_cur)
  );

  xfs_decide #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_dec (
    .acc            (acc_e'(acc_kind)),
    .user_mode      (user_mode),
    .ifetch_xlat_en (ifetch_xlat_en),
    .data_xlat_en   (data_xlat_en),
    .blk_hit        (blk_hit),
    .blk_perm       (blk_perm),
    .blk_pa         (blk_pa),
    .ea             (eff_addr),
    .seg            (seg_cur),
    .walk_found     (walk_found),
    .walk_pp        (walk_pp),
    .walk_rpn       (walk_rpn),
    .d_grant        (d_grant),
    .d_pa           (d_pa),
    .d_perm         (d_perm),
    .d_finstr       (d_finstr),
    .d_fdata        (d_fdata),
    .d_status       (d_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      grant       <= 1'b0;
      phys_addr   <= '0;
      perm        <= '0;
      fault_instr <= 1'b0;
      fault_data  <= 1'b0;
      status      <= '0;
      fault_addr  <= '0;
    end else if (accept) begin
      resp_valid  <= 1'b1;
      grant       <= d_grant;
      phys_addr   <= d_pa;
      perm        <= d_perm;
      fault_instr <= d_finstr;
      fault_data  <= d_fdata;
      status      <= d_status;
      if (d_fdata) fault_addr <= eff_addr;
    end else if (resp_ack) begin
      resp_valid  <= 1'b0;
    end
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ack) |=> (resp_valid && $stable(phys_addr) &&
      $stable(status) && $stable(perm) && $stable(grant) && $stable(fault_addr)));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($onehot0({grant, fault_instr, fault_data}) &&
                    (grant || fault_instr || fault_data)));

  // R11
  fetch_side_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && acc_kind == 2'd0) |=> !fault_data);

  // R11
  fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!fault_data || fault_addr == $past(eff_addr)));

  // R1
  real_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && ((acc_kind == 2'd0) ? !ifetch_xlat_en : !data_xlat_en))
      |=> (grant && perm == 3'b111 && phys_addr == $past(eff_addr)));

  // R5
  nx_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && acc_kind == 2'd0 && ifetch_xlat_en && !blk_hit &&
     !seg_cur[SEG_DS] && seg_cur[SEG_NOX])
      |=> (fault_instr && status == ST_NOEXEC));
endmodule

// File: tb/xfs_top_tb.sv
module xfs_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, resp_valid, resp_ack;
  logic [1:0]  acc_kind;
  logic        user_mode, ifetch_xlat_en, data_xlat_en, blk_hit;
  logic [2:0]  blk_perm;
  logic [31:0] blk_pa, eff_addr;
  logic [511:0] seg_file;
  logic        walk_found;
  logic [1:0]  walk_pp;
  logic [19:0] walk_rpn;
  logic        grant, fault_instr, fault_data;
  logic [31:0] phys_addr, status, fault_addr;
  logic [2:0]  perm;

  logic [31:0] segw [16];
  int total = 0;
  int bad   = 0;

  // expected values
  logic        e_grant, e_fi, e_fd;
  logic [31:0] e_pa, e_st, e_fa;
  logic [2:0]  e_perm;
  string       e_tag;

  always #(CLK_P/2) clk = ~clk;

  for (genvar g = 0; g < 16; g++) begin : g_pack
    assign seg_file[g*32 +: 32] = segw[g];
  end

  xfs_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .acc_kind(acc_kind), .user_mode(user_mode),
    .ifetch_xlat_en(ifetch_xlat_en), .data_xlat_en(data_xlat_en),
    .blk_hit(blk_hit), .blk_perm(blk_perm), .blk_pa(blk_pa),
    .eff_addr(eff_addr), .seg_file(seg_file), .walk_found(walk_found),
    .walk_pp(walk_pp), .walk_rpn(walk_rpn), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .grant(grant), .phys_addr(phys_addr), .perm(perm),
    .fault_instr(fault_instr), .fault_data(fault_data), .status(status),
    .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_fault(input logic fetch, input logic store,
                           input logic [31:0] base, input logic [31:0] st_code);
    e_fi = fetch;
    e_fd = !fetch;
    e_st = store ? st_code : base;
  endtask

  // reference model written from the requirements
  task automatic model();
    logic fetch, store, xon, key;
    logic [2:0]  need, pperm;
    logic [31:0] sg;
    fetch = (acc_kind == 2'd0);
    store = (acc_kind == 2'd2);
    need  = fetch ? 3'b100 : (store ? 3'b010 : 3'b001);
    xon   = fetch ? ifetch_xlat_en : data_xlat_en;
    sg    = segw[eff_addr[31:28]];
    key   = user_mode ? sg[29] : sg[30];
    if (!key) pperm = (walk_pp == 2'd3) ? 3'b001 : 3'b011;
    else pperm = (walk_pp == 2'd0) ? 3'b000 : ((walk_pp == 2'd2) ? 3'b011 : 3'b001);
    if (!sg[28]) pperm[2] = 1'b1;
    e_grant = 0; e_fi = 0; e_fd = 0; e_pa = 0; e_perm = 0; e_st = 0;
    if (!xon) begin
      e_tag = "R1"; e_grant = 1; e_pa = eff_addr; e_perm = 3'b111;
    end else if (blk_hit) begin
      e_tag = "R2";
      if ((need & ~blk_perm) != 0) set_fault(fetch, store, 32'h0800_0000, 32'h0A00_0000);
      else begin e_grant = 1; e_pa = blk_pa; e_perm = blk_perm; end
    end else if (sg[31]) begin
      if (sg[28:20] == 9'h07F) begin
        e_tag = "R7"; e_grant = 1; e_pa = {sg[3:0], eff_addr[27:0]}; e_perm = 3'b111;
      end else if (fetch) begin
        e_tag = "R6"; e_fi = 1; e_st = 32'h1000_0000;
      end else begin
        e_tag = "R8";
        if ((store && key) || (!store && !key)) set_fault(0, store, 32'h0800_0000, 32'h0A00_0000);
        else begin e_grant = 1; e_pa = eff_addr; e_perm = 3'b011; end
      end
    end else if (fetch && sg[28]) begin
      e_tag = "R5"; e_fi = 1; e_st = 32'h1000_0000;
    end else if (!walk_found) begin
      e_tag = "R9"; set_fault(fetch, store, 32'h4000_0000, 32'h4200_0000);
    end else begin
      e_tag = "R4";
      if ((need & ~pperm) != 0) begin
        e_tag = "R10"; set_fault(fetch, store, 32'h0800_0000, 32'h0A00_0000);
      end else begin e_grant = 1; e_pa = {walk_rpn, eff_addr[11:0]}; e_perm = pperm; end
    end
    if (e_fd) e_fa = eff_addr;
  endtask

  task automatic run_xact(input int hold);
    logic [31:0] h_pa, h_st;
    @(negedge clk);
    req_valid = 1'b1;
    model();
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "resp_valid", {31'd0, resp_valid}, 32'd1);
    chk(e_tag, "grant", {31'd0, grant}, {31'd0, e_grant});
    chk(e_tag, "phys_addr", phys_addr, e_pa);
    chk(e_tag, "perm", {29'd0, perm}, {29'd0, e_perm});
    chk("R11", "fault_sides", {30'd0, fault_instr, fault_data}, {30'd0, e_fi, e_fd});
    chk(e_tag, "status", status, e_st);
    chk("R11", "fault_addr", fault_addr, e_fa);
    h_pa = phys_addr; h_st = status;
    for (int i = 0; i < hold; i++) begin
      req_valid = 1'b1;
      eff_addr  = $urandom;
      acc_kind  = 2'($urandom);
      @(negedge clk);
      chk("R12", "ready_low", {31'd0, req_ready}, 32'd0);
      chk("R12", "held_pa", phys_addr, h_pa);
      chk("R12", "held_status", status, h_st);
      chk("R12", "held_faddr", fault_addr, e_fa);
    end
    req_valid = 1'b0;
    resp_ack  = 1'b1;
    @(negedge clk);
    resp_ack = 1'b0;
    chk("R12", "released", {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  task automatic base_req(input logic [1:0] acc, input logic [31:0] ea);
    acc_kind = acc; eff_addr = ea; user_mode = 0;
    ifetch_xlat_en = 1; data_xlat_en = 1; blk_hit = 0; blk_perm = 0;
    blk_pa = 0; walk_found = 1; walk_pp = 2'd2; walk_rpn = 20'hABCDE;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; req_valid = 0; resp_ack = 0; e_fa = 0;
    for (int i = 0; i < 16; i++) segw[i] = 32'h0;
    base_req(2'd1, 32'h0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12", "reset_valid_ready", {30'd0, resp_valid, req_ready}, 32'd1);
    chk("R12", "reset_outputs", {28'd0, grant, fault_instr, fault_data, |perm}, 32'd0);
    chk("R12", "reset_status", status | phys_addr | fault_addr, 32'd0);

    // R1: fetch side off, data side on
    base_req(2'd0, 32'h1234_5678); ifetch_xlat_en = 0; run_xact(0);
    base_req(2'd2, 32'h8765_4321); data_xlat_en = 0; ifetch_xlat_en = 0; run_xact(2);
    // R2: block grant, block store without write, walk ignored
    base_req(2'd1, 32'h3000_0010); blk_hit = 1; blk_perm = 3'b101; blk_pa = 32'h0055_0000;
    walk_found = 0; run_xact(0);
    base_req(2'd2, 32'h3000_0020); blk_hit = 1; blk_perm = 3'b101; run_xact(0);
    base_req(2'd0, 32'h3000_0030); blk_hit = 1; blk_perm = 3'b011; run_xact(0);
    // R3/R4: every key and protection combination
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++) begin
        segw[5] = {1'b0, k[1], k[0], 29'd0};
        for (int pp = 0; pp < 4; pp++)
          for (int a = 0; a < 3; a++) begin
            base_req(2'(a), 32'h5000_1ABC); user_mode = u[0]; walk_pp = 2'(pp);
            run_xact(0);
          end
      end
    // R5: no-exec segment fetch vs load, segment index matters (R3)
    segw[6] = 32'h1000_0000; segw[7] = 32'h0;
    base_req(2'd0, 32'h6000_0100); run_xact(0);
    base_req(2'd0, 32'h7000_0100); run_xact(0);
    base_req(2'd1, 32'h6000_0100); run_xact(0);
    // R6/R7/R8: direct-store
    segw[8] = 32'h8000_0000 | (32'h07F << 20) | 32'h9;
    segw[9] = 32'hC010_0000; // key_sup=1
    base_req(2'd0, 32'h8123_4567); run_xact(0);
    base_req(2'd2, 32'h8ABC_DEF0); run_xact(0);
    base_req(2'd0, 32'h9000_0004); run_xact(0);
    base_req(2'd1, 32'h9000_0008); run_xact(0);
    base_req(2'd2, 32'h9000_000C); run_xact(0);
    base_req(2'd1, 32'h9000_0010); user_mode = 1; run_xact(0);
    base_req(2'd2, 32'h9000_0014); user_mode = 1; run_xact(1);
    // R9: miss codes
    segw[10] = 32'h0;
    base_req(2'd0, 32'hA000_0000); walk_found = 0; run_xact(0);
    base_req(2'd1, 32'hA000_0040); walk_found = 0; run_xact(0);
    base_req(2'd2, 32'hA000_0080); walk_found = 0; run_xact(0);
    base_req(2'd3, 32'hA000_00C0); walk_found = 0; run_xact(0);
    // R10: page store protection
    segw[10] = 32'h4000_0000;
    base_req(2'd2, 32'hA000_0100); walk_pp = 2'd3; run_xact(0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 16; i++) begin
        segw[i] = $urandom;
        if (($urandom % 4) != 0) segw[i][31] = 1'b0;
        if (($urandom % 6) == 0) segw[i][28:20] = 9'h07F;
      end
      acc_kind = 2'($urandom); eff_addr = $urandom; user_mode = 1'($urandom);
      ifetch_xlat_en = (($urandom % 8) != 0); data_xlat_en = (($urandom % 8) != 0);
      blk_hit = (($urandom % 5) == 0); blk_perm = 3'($urandom); blk_pa = $urandom;
      walk_found = (($urandom % 6) != 0); walk_pp = 2'($urandom); walk_rpn = 20'($urandom);
      run_xact(int'($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule